// File: doc/BRIEF.md
# Hot-Swap Slot Fault Supervisor

This block is the digital control for one hot-swap power slot. The slot has two power groups. The main group switches a set of supply rails together. The auxiliary output is a single standby rail. Each group is requested through a dedicated input pin or through a control register bit. The two sources are ORed. Each group has its own circuit breaker, and once a breaker trips it stays tripped until that group's request is dropped. When a group is off, its discharge control is driven active.

Analog comparators supply the per-rail flags for slow overcurrent, fast overcurrent and input undervoltage, plus one slow-overcurrent flag for the auxiliary rail. An external `tick` sets the time base of a programmable fault timer, and each group has its own copy of that timer. Trips are recorded in write-one-to-clear status bits, which drive an active-low interrupt through a mask register. The active-low fault pin reports only trips on groups that had been requested through their pin.

The register port is a plain single-cycle write strobe with no handshake. A write always completes in the cycle it is presented, and nothing can stall it. No data path is streamed, so the block has no valid/ready interface.

Top module: `hsw_slot_supervisor`

## Requirements
- R1: While the main group is on and any main slow-overcurrent flag is high, the main timer counts `tick` pulses. On the Nth such tick, with N = max(limit, 1), the main breaker trips and `main_en` goes low in the following cycle. The limit is held in register address 3, bits [7:0], and resets to 4. `aux_en` is not affected.
- R2: If any main fast-overcurrent flag is high while the main group is on, the main breaker trips at the next clock edge, with no timer delay.
- R3: Undervoltage on any main rail trips the main breaker only while the main group is on. While the main group is off, undervoltage changes no output and no status bit.
- R4: The auxiliary breaker trips only through its own timer, which has the same rule as R1 but uses `aux_oc` and `tick`. Main-group flags have no effect on it. `aux_en` also requires `stby_ok`.
- R5: A tripped group stays off while its request is held. Its request is its pin ORed with its control bit: address 0, bit 0 for main and bit 1 for aux. Dropping the request clears the trip, and raising the request again turns the group back on.
- R6: `fault_n` is low while a tripped group is latched and that group's pin was high at the moment of its trip. A trip with only the control bit requesting the group leaves `fault_n` high.
- R7: A trip sets a status bit at address 1: bit 0 for main, bit 1 for aux. `irq_n` is low while any status bit is set and its mask bit at address 2 (same positions) is clear.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. A trip in the same cycle as the clear wins.
- R9: `main_dis` is the inverse of `main_en`, and `aux_dis` is the inverse of `aux_en`.
- R10: A timer returns to zero in any cycle where its overcurrent flag is low or its group is off, so the next trip needs a full N ticks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| on_pin | input | 1 | Main group request pin |
| aux_pin | input | 1 | Auxiliary request pin |
| stby_ok | input | 1 | Standby supply present |
| slow_oc | input | NRAIL | Per-rail slow overcurrent flags |
| fast_oc | input | NRAIL | Per-rail fast overcurrent flags |
| uv_flag | input | NRAIL | Per-rail input undervoltage flags |
| aux_oc | input | 1 | Auxiliary overcurrent flag |
| tick | input | 1 | Fault timer time base |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| main_en | output | 1 | Main rails enable |
| aux_en | output | 1 | Auxiliary rail enable |
| main_dis | output | 1 | Main discharge switch control |
| aux_dis | output | 1 | Auxiliary discharge switch control |
| fault_n | output | 1 | Active-low fault pin |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach is a timer interrupted just short of expiry: the overcurrent flag must be held for N-1 ticks, dropped for exactly one cycle, and then held again. Random flag toggling almost never lines up this way. A directed sequence builds it with a limit of 3, and random runs with small limits cover the other interleavings. A second case that is hard to reach is a trip and a write-one-to-clear landing on the same bit in the same cycle. The random phase writes the status register often while faults are frequent, so such collisions occur.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam int NGRP   = 2;
  localparam int G_MAIN = 0;
  localparam int G_AUX  = 1;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_MASK = 2'd2,
    REG_TLIM = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/hsw_fault_timer.sv
module hsw_fault_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   lim_eff;
  logic [CNT_W:0]   cnt_nx;

  always_comb begin
    lim_eff = (limit == '0) ? {{CNT_W{1'b0}}, 1'b1} : {1'b0, limit};
    cnt_nx  = {1'b0, cnt_q} + 1'b1;
    expire  = arm && tick && (cnt_nx >= lim_eff);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!arm || expire)  cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_nx[CNT_W-1:0];
  end

  // R10: a dropped flag returns the count to zero
  p_cnt_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (cnt_q == '0));
  // R1: no tick, no advance
  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/hsw_breaker.sv
module hsw_breaker (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic pin,
  input  logic trip_set,
  output logic tripped,
  output logic pin_fault
);
  logic trip_q, pin_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      pin_q  <= 1'b0;
    end else if (trip_set) begin
      trip_q <= 1'b1;
      pin_q  <= pin;
    end else if (!req) begin
      trip_q <= 1'b0;
      pin_q  <= 1'b0;
    end
  end

  assign tripped   = trip_q;
  assign pin_fault = trip_q & pin_q;

  // R5: a latched trip survives while the request is held
  p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_q && req) |=> trip_q);
  // R5: a dropped request without a new trip releases the latch
  p_latch_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && !trip_set) |=> !trip_q);
endmodule

// File: rtl/hsw_regs.sv
module hsw_regs
  import hsw_pkg::*;
#(
  parameter int LIM_W   = 8,
  parameter int LIM_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [NGRP-1:0]   flt_set,
  output logic [NGRP-1:0]   ctrl,
  output logic [LIM_W-1:0]  limit,
  output logic              irq_n
);
  logic [NGRP-1:0] stat_q, mask_q, w1c;

  assign w1c = (wr_en && wr_addr == REG_STAT) ? wr_data[NGRP-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      mask_q <= '0;
      stat_q <= '0;
      limit  <= LIM_W'(LIM_RST);
    end else begin
      stat_q <= (stat_q & ~w1c) | flt_set;
      if (wr_en) begin
        case (reg_addr_e'(wr_addr))
          REG_CTRL: ctrl   <= wr_data[NGRP-1:0];
          REG_MASK: mask_q <= wr_data[NGRP-1:0];
          REG_TLIM: limit  <= wr_data[LIM_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  assign irq_n = ~|(stat_q & ~mask_q);

  // R8: bits not written with 1 never drop
  p_w1c_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(w1c)) & ~stat_q) == '0));
  // R8: a written 1 without a concurrent trip clears
  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(w1c) & ~$past(flt_set)) == '0));
  // R7: every trip leaves its status bit set
  p_stat_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(flt_set)) == $past(flt_set)));
endmodule

// File: rtl/hsw_slot_supervisor.sv
module hsw_slot_supervisor
  import hsw_pkg::*;
#(
  parameter int NRAIL   = 4,
  parameter int TMR_W   = 8,
  parameter int LIM_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              on_pin,
  input  logic              aux_pin,
  input  logic              stby_ok,
  input  logic [NRAIL-1:0]  slow_oc,
  input  logic [NRAIL-1:0]  fast_oc,
  input  logic [NRAIL-1:0]  uv_flag,
  input  logic              aux_oc,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              main_en,
  output logic              aux_en,
  output logic              main_dis,
  output logic              aux_dis,
  output logic              fault_n,
  output logic              irq_n
);
  logic [NGRP-1:0]  ctrl, pins, req, on, arm, expire, set, tripped, pin_flt;
  logic [TMR_W-1:0] limit;

  assign pins = {aux_pin, on_pin};
  assign req  = pins | ctrl;

  always_comb begin
    on[G_MAIN]  = req[G_MAIN] & ~tripped[G_MAIN];
    on[G_AUX]   = req[G_AUX]  & ~tripped[G_AUX] & stby_ok;
    arm[G_MAIN] = on[G_MAIN] & (|slow_oc);
    arm[G_AUX]  = on[G_AUX]  & aux_oc;
    set[G_MAIN] = on[G_MAIN] & ((|fast_oc) | (|uv_flag) | expire[G_MAIN]);
    set[G_AUX]  = expire[G_AUX];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    hsw_fault_timer #(.CNT_W(TMR_W)) tmr_i (
      .clk(clk), .rst_n(rst_n), .arm(arm[g]), .tick(tick),
      .limit(limit), .expire(expire[g])
    );
    hsw_breaker brk_i (
      .clk(clk), .rst_n(rst_n), .req(req[g]), .pin(pins[g]),
      .trip_set(set[g]), .tripped(tripped[g]), .pin_fault(pin_flt[g])
    );
  end

  hsw_regs #(.LIM_W(TMR_W), .LIM_RST(LIM_RST)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .flt_set(set), .ctrl(ctrl), .limit(limit),
    .irq_n(irq_n)
  );

  assign main_en  = on[G_MAIN];
  assign aux_en   = on[G_AUX];
  assign main_dis = ~on[G_MAIN];
  assign aux_dis  = ~on[G_AUX];
  assign fault_n  = ~|pin_flt;

  // R2: fast overcurrent while on removes the main group at the next edge
  p_fast_trip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en && |fast_oc) |=> !main_en);
  // R3: undervoltage while on removes the main group at the next edge
  p_uv_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_en && |uv_flag) |=> !main_en);
  // R3: a main trip only starts from an enabled group
  p_uv_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped[G_MAIN]) |-> $past(main_en));
  // R4: the auxiliary breaker only trips through its timer
  p_aux_timer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tripped[G_AUX]) |-> $past(expire[G_AUX]));
  // R4: auxiliary trips never come from main flags alone
  p_aux_indep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_en && !aux_oc && stby_ok && req[G_AUX]) |=> (tripped[G_AUX] == 1'b0));
endmodule

// File: tb/hsw_slot_supervisor_tb_top.sv
`timescale 1ns/1ps
module hsw_slot_supervisor_tb_top;
  localparam int NR = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic on_pin = 0, aux_pin = 0, stby_ok = 1, aux_oc = 0, tick = 0;
  logic [NR-1:0] slow_oc = '0, fast_oc = '0, uv_flag = '0;
  logic wr_en = 0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic main_en, aux_en, main_dis, aux_dis, fault_n, irq_n;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hsw_slot_supervisor #(.NRAIL(NR), .TMR_W(8), .LIM_RST(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .on_pin(on_pin), .aux_pin(aux_pin),
    .stby_ok(stby_ok), .slow_oc(slow_oc), .fast_oc(fast_oc),
    .uv_flag(uv_flag), .aux_oc(aux_oc), .tick(tick), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .main_en(main_en),
    .aux_en(aux_en), .main_dis(main_dis), .aux_dis(aux_dis),
    .fault_n(fault_n), .irq_n(irq_n)
  );

  // reference model state
  bit m_trip, a_trip, m_pin, a_pin;
  bit [1:0] m_ctrl, m_stat, m_mask;
  int m_cnt, a_cnt, m_lim;

  function automatic bit f_mreq(); return on_pin | m_ctrl[0]; endfunction
  function automatic bit f_areq(); return aux_pin | m_ctrl[1]; endfunction
  function automatic bit f_men();  return f_mreq() & !m_trip; endfunction
  function automatic bit f_aen();  return f_areq() & !a_trip & stby_ok; endfunction
  function automatic int f_lim();  return (m_lim == 0) ? 1 : m_lim; endfunction

  always @(posedge clk) begin
    bit mexp, aexp, mset, aset;
    bit [1:0] clr;
    if (!rst_n) begin
      m_trip <= 0; a_trip <= 0; m_pin <= 0; a_pin <= 0;
      m_ctrl <= 0; m_stat <= 0; m_mask <= 0; m_cnt <= 0; a_cnt <= 0; m_lim <= 4;
    end else begin
      mexp = f_men() && (|slow_oc) && tick && (m_cnt + 1 >= f_lim());
      aexp = f_aen() && aux_oc && tick && (a_cnt + 1 >= f_lim());
      if (!(f_men() && |slow_oc) || mexp) m_cnt <= 0; else if (tick) m_cnt <= m_cnt + 1;
      if (!(f_aen() && aux_oc) || aexp)   a_cnt <= 0; else if (tick) a_cnt <= a_cnt + 1;
      mset = f_men() && ((|fast_oc) || (|uv_flag) || mexp);
      aset = aexp;
      if (mset) begin m_trip <= 1; m_pin <= on_pin; end
      else if (!f_mreq()) begin m_trip <= 0; m_pin <= 0; end
      if (aset) begin a_trip <= 1; a_pin <= aux_pin; end
      else if (!f_areq()) begin a_trip <= 0; a_pin <= 0; end
      clr = (wr_en && wr_addr == 2'd1) ? wr_data[1:0] : 2'b00;
      m_stat <= (m_stat & ~clr) | {aset, mset};
      if (wr_en && wr_addr == 2'd0) m_ctrl <= wr_data[1:0];
      if (wr_en && wr_addr == 2'd2) m_mask <= wr_data[1:0];
      if (wr_en && wr_addr == 2'd3) m_lim  <= int'(wr_data);
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk(main_en,  f_men(),  "R1 R2 R3 R5 main_en");
    chk(aux_en,   f_aen(),  "R4 R5 aux_en");
    chk(main_dis, !f_men(), "R9 main_dis");
    chk(aux_dis,  !f_aen(), "R9 aux_dis");
    chk(fault_n,  !((m_trip & m_pin) | (a_trip & a_pin)), "R6 fault_n");
    chk(irq_n,    !(|(m_stat & ~m_mask)), "R7 R8 irq_n");
  endtask

  task automatic cyc(); @(posedge clk); @(negedge clk); compare_all(); endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; cyc(); wr_en = 0;
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    cyc();
    // reset state
    chk(main_en, 0, "R9 reset main_en"); chk(main_dis, 1, "R9 reset main_dis");
    chk(fault_n, 1, "R6 reset"); chk(irq_n, 1, "R7 reset");

    // R1 slow trip after N ticks, aux unaffected
    on_pin = 1; aux_pin = 1; wr(2'd3, 8'd3); cyc();
    slow_oc = 4'b0100; tick = 1; cyc(); cyc();
    chk(main_en, 1, "R1 before expiry");
    cyc();
    chk(main_en, 0, "R1 tripped"); chk(aux_en, 1, "R1 aux stays");
    chk(fault_n, 0, "R6 pin trip"); chk(irq_n, 0, "R7 irq");
    // R5 held request keeps it off, cycle restores
    slow_oc = 0; cyc(); cyc(); chk(main_en, 0, "R5 held off");
    on_pin = 0; cyc(); on_pin = 1; cyc(); chk(main_en, 1, "R5 re-enabled");
    // R8 write 0 ignored, write 1 clears
    wr(2'd1, 8'h00); chk(irq_n, 0, "R8 write zero");
    wr(2'd1, 8'h01); chk(irq_n, 1, "R8 write one");
    // R3 undervoltage ignored while off
    on_pin = 0; cyc(); uv_flag = 4'b0001; cyc(); cyc();
    chk(irq_n, 1, "R3 uv off"); chk(aux_en, 1, "R4 aux during uv");
    uv_flag = 0; on_pin = 1; cyc(); chk(main_en, 1, "R3 on again");
    uv_flag = 4'b1000; cyc(); chk(main_en, 0, "R3 uv trip");
    uv_flag = 0; on_pin = 0; wr(2'd1, 8'h03);
    // R6 control-bit request: no fault pin; R7 mask
    wr(2'd2, 8'h01); wr(2'd0, 8'h01); chk(main_en, 1, "R5 ctrl enable");
    fast_oc = 4'b0010; cyc(); fast_oc = 0;
    chk(main_en, 0, "R2 fast trip"); chk(fault_n, 1, "R6 ctrl trip");
    chk(irq_n, 1, "R7 masked");
    wr(2'd0, 8'h00); wr(2'd0, 8'h01); chk(main_en, 1, "R5 ctrl toggle clears");
    wr(2'd2, 8'h00); chk(irq_n, 0, "R7 unmasked");
    wr(2'd1, 8'h01); wr(2'd0, 8'h00);
    // R10 interrupted count
    on_pin = 1; cyc(); slow_oc = 4'b0001; cyc(); cyc();
    slow_oc = 0; cyc(); slow_oc = 4'b0001; cyc(); cyc();
    chk(main_en, 1, "R10 restart"); cyc(); chk(main_en, 0, "R10 full count");
    slow_oc = 0; on_pin = 0; cyc(); on_pin = 1;
    // R4 aux timer, no fast path, needs standby
    aux_oc = 1; fast_oc = 4'b1111; tick = 0; cyc(); fast_oc = 0;
    chk(aux_en, 1, "R4 no fast path");
    tick = 1; cyc(); cyc(); cyc(); chk(aux_en, 0, "R4 aux trip");
    aux_oc = 0; aux_pin = 0; cyc(); aux_pin = 1; cyc(); chk(aux_en, 1, "R4 R5 aux back");
    stby_ok = 0; cyc(); chk(aux_en, 0, "R4 standby lost"); stby_ok = 1;
    wr(2'd1, 8'h03);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 2) == 0;
      if ($urandom % 20 == 0) slow_oc = ($urandom % 3 == 0) ? 4'($urandom) : '0;
      if ($urandom % 15 == 0) aux_oc = !aux_oc;
      fast_oc = ($urandom % 60 == 0) ? 4'($urandom) : '0;
      uv_flag = ($urandom % 50 == 0) ? 4'($urandom) : '0;
      if ($urandom % 12 == 0) on_pin = !on_pin;
      if ($urandom % 12 == 0) aux_pin = !aux_pin;
      stby_ok = ($urandom % 40) != 0;
      wr_en = ($urandom % 6 == 0);
      wr_addr = 2'($urandom);
      wr_data = (wr_addr == 2'd3) ? 8'($urandom % 6) : 8'($urandom);
      cyc();
      wr_en = 0;
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule